// File: doc/BRIEF.md
# Ringed SAD Processing-Element Array

This block is the arithmetic core of a full-search block-matching motion estimator. A grid of H columns by V rows of identical elements scores H x V candidate displacements at the same time. Every element computes the sum of absolute differences (SAD) between the current block and one candidate. The pixels of the N x N current block arrive one per accepted cycle, in raster order, and every element receives the same pixel. Each element also takes one search-area pixel per accepted cycle from its own dedicated memory port. No element ever reads another element's memory.

Each partial sum does not stay in one element. Every accepted cycle, each element takes the running sum held by a neighbour, adds its own new absolute difference, and keeps the result. Within a row of the current block, the neighbour is the next element to the right on a horizontal ring. At the start of each new block row, the neighbour is the element below on a vertical ring. Both rings wrap at the array edges. After N*N accepted pixels, every element holds the full SAD of one candidate. That value is copied into a result latch and announced with a single-cycle strobe. The next batch of candidates can begin on the very next cycle. Search-area addressing and minimum selection belong to surrounding logic.

Top module: `sad_ring_array`

## Requirements
- R1: While `rst` is high on a rising edge, the edge clears every running sum, every result latch, the pixel position and `res_valid`. After reset, `res_valid` reads 0 and every field of `res_sad` reads 0.
- R2: Element e = r*H + c drives `ref_pix[e*PW +: PW]` and `res_sad[e*ACC_W +: ACC_W]`. The first pixel of a batch starts each element's sum from zero. For pixel index t with t mod N != 0, element (r,c) adds its difference to the sum held by (r,(c+1) mod H). For t mod N == 0 and t > 0, it adds to the sum held by ((r+1) mod V, c). The latched result of each element equals the sum along that path.
- R3: Suppose every element reads the search-window pixel that the ring path assigns to its final candidate. Then element (r,c) reports the direct SAD of the current block against the window offset by r rows and c columns.
- R4: `res_valid` is high for exactly one cycle. That cycle follows the rising edge that accepted the N*N-th pixel of a batch.
- R5: A cycle with `cur_valid` low changes no sum and no position, and does not raise `res_valid`, whatever the pixel inputs carry.
- R6: A new batch may start on the cycle right after the last pixel of the previous one, with no idle cycles. Both batches then report correct results.
- R7: The result latches hold their values, and `res_valid` stays low, until the next batch completes.
- R8: `ACC_W` = PW + clog2(N*N). The all-maximum difference N*N*(2^PW - 1) is reported exactly, with no wrap.
- R9: A reset in the middle of a batch discards the partial sums. The next batch counts its pixels from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cur_valid | input | 1 | Current-block pixel and search pixels are valid this cycle |
| cur_pix | input | PW | Current-block pixel, broadcast to all elements |
| ref_pix | input | H*V*PW | One search-area pixel per element, element e in bits e*PW upward |
| res_valid | output | 1 | One-cycle strobe when the result latches update |
| res_sad | output | H*V*ACC_W | Latched SAD per element, element e in bits e*ACC_W upward |

## Verification
The result latch of a finished batch and the first accumulation of the next batch fall into the same cycle when batches run back to back. In that cycle, the sums restart from zero while the latches capture the old totals. The bench provokes this by chaining several randomly filled batches with no gap. At the strobe of each batch, it compares every element against the path sums computed for that batch alone. Any leakage between the outgoing and incoming batches then shows up as a mismatch in one of the two.

// File: rtl/sad_ring_pkg.sv
package sad_ring_pkg;

    // Which running sum an element adds its new absolute difference to.
    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,   // first pixel of a batch
        SRC_HORZ = 2'd1,   // neighbour along the horizontal ring
        SRC_VERT = 2'd2    // neighbour along the vertical ring
    } src_sel_e;

endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] a,
    input  logic [PW-1:0] b,
    output logic [PW-1:0] d
);
    always_comb begin
        if (a >= b) d = a - b;
        else        d = b - a;
    end
endmodule

// File: rtl/sad_pe.sv
module sad_pe
    import sad_ring_pkg::*;
#(
    parameter int PW    = 8,
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  src_sel_e         src_sel,
    input  logic             last,
    input  logic [ACC_W-1:0] horz_in,
    input  logic [ACC_W-1:0] vert_in,
    input  logic [PW-1:0]    cur_pix,
    input  logic [PW-1:0]    ref_pix,
    output logic [ACC_W-1:0] acc_out,
    output logic [ACC_W-1:0] res_out
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] res;
    } pe_st_t;

    pe_st_t           st_d, st_q;
    logic [PW-1:0]    diff;
    logic [ACC_W-1:0] base;

    sad_absdiff #(.PW(PW)) i_absdiff (
        .a (cur_pix),
        .b (ref_pix),
        .d (diff)
    );

    always_comb begin
        st_d = st_q;
        unique case (src_sel)
            SRC_HORZ: base = horz_in;
            SRC_VERT: base = vert_in;
            default:  base = '0;
        endcase
        if (en) begin
            st_d.acc = base + ACC_W'(diff);
            if (last) st_d.res = st_d.acc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_out = st_q.acc;
    assign res_out = st_q.res;
endmodule

// File: rtl/sad_ring_seq.sv
module sad_ring_seq
    import sad_ring_pkg::*;
#(
    parameter int N = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     step_valid,
    output src_sel_e src_sel,
    output logic     batch_last,
    output logic     done_q
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IW-1:0] col;
        logic [IW-1:0] row;
        logic          done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        batch_last = step_valid && (st_q.col == IW'(N-1)) && (st_q.row == IW'(N-1));
        if (st_q.col != '0)       src_sel = SRC_HORZ;
        else if (st_q.row != '0)  src_sel = SRC_VERT;
        else                      src_sel = SRC_ZERO;
        if (step_valid) begin
            if (st_q.col == IW'(N-1)) begin
                st_d.col = '0;
                st_d.row = (st_q.row == IW'(N-1)) ? '0 : st_q.row + 1'b1;
            end else begin
                st_d.col = st_q.col + 1'b1;
            end
            st_d.done = batch_last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign done_q = st_q.done;
endmodule

// File: rtl/sad_ring_array.sv
module sad_ring_array
    import sad_ring_pkg::*;
#(
    parameter int H  = 4,
    parameter int V  = 4,
    parameter int N  = 4,
    parameter int PW = 8,
    localparam int NE    = H * V,
    localparam int ACC_W = PW + $clog2(N * N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cur_valid,
    input  logic [PW-1:0]       cur_pix,
    input  logic [NE*PW-1:0]    ref_pix,
    output logic                res_valid,
    output logic [NE*ACC_W-1:0] res_sad
);
    src_sel_e         src_sel;
    logic             batch_last;
    logic [ACC_W-1:0] acc_w [NE];

    sad_ring_seq #(.N(N)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .step_valid (cur_valid),
        .src_sel    (src_sel),
        .batch_last (batch_last),
        .done_q     (res_valid)
    );

    for (genvar r = 0; r < V; r++) begin : g_row
        for (genvar c = 0; c < H; c++) begin : g_col
            localparam int E  = r * H + c;
            localparam int EH = r * H + ((c + 1) % H);
            localparam int EV = ((r + 1) % V) * H + c;

            sad_pe #(.PW(PW), .ACC_W(ACC_W)) i_pe (
                .clk     (clk),
                .rst     (rst),
                .en      (cur_valid),
                .src_sel (src_sel),
                .last    (batch_last),
                .horz_in (acc_w[EH]),
                .vert_in (acc_w[EV]),
                .cur_pix (cur_pix),
                .ref_pix (ref_pix[E*PW +: PW]),
                .acc_out (acc_w[E]),
                .res_out (res_sad[E*ACC_W +: ACC_W])
            );
        end
    end
endmodule

// File: rtl/sad_ring_chk.sv
module sad_ring_chk #(
    parameter int H  = 4,
    parameter int V  = 4,
    parameter int N  = 4,
    parameter int PW = 8,
    localparam int NE    = H * V,
    localparam int NN    = N * N,
    localparam int ACC_W = PW + $clog2(NN),
    localparam int CW    = (NN > 1) ? $clog2(NN) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic                cur_valid,
    input logic                res_valid,
    input logic [NE*ACC_W-1:0] res_sad
);
    localparam logic [ACC_W-1:0] SAD_MAX = ACC_W'(NN * ((1 << PW) - 1));

    logic [CW-1:0] beats_q;
    logic          rst_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            beats_q <= '0;
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (cur_valid) beats_q <= (beats_q == CW'(NN-1)) ? '0 : beats_q + 1'b1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!res_valid && res_sad == '0));

    assert_strobe_after_last_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_valid && beats_q == CW'(NN-1)) |=> res_valid);

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_no_strobe_on_stall_R5: assert property (@(posedge clk) disable iff (rst)
        !cur_valid |=> !res_valid);

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !res_valid) |-> $stable(res_sad));

    for (genvar e = 0; e < NE; e++) begin : g_ovf
        assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
            res_valid |-> (res_sad[e*ACC_W +: ACC_W] <= SAD_MAX));
    end
endmodule

bind sad_ring_array sad_ring_chk #(.H(H), .V(V), .N(N), .PW(PW)) i_sad_ring_chk (
    .clk       (clk),
    .rst       (rst),
    .cur_valid (cur_valid),
    .res_valid (res_valid),
    .res_sad   (res_sad)
);

// File: tb/test_sad_ring_array.sv
module test_sad_ring_array;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int H  = 4;
    localparam int V  = 4;
    localparam int N  = 4;
    localparam int PW = 8;
    localparam int NE = H * V;
    localparam int NN = N * N;
    localparam int AW = PW + $clog2(NN);
    localparam int PMAX = (1 << PW) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cur_valid = 1'b0;
    logic [PW-1:0]     cur_pix = '0;
    logic [NE*PW-1:0]  ref_pix = '0;
    logic              res_valid;
    logic [NE*AW-1:0]  res_sad;

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    sad_ring_array #(.H(H), .V(V), .N(N), .PW(PW)) i_sad_ring_array (
        .clk       (clk),
        .rst       (rst),
        .cur_valid (cur_valid),
        .cur_pix   (cur_pix),
        .ref_pix   (ref_pix),
        .res_valid (res_valid),
        .res_sad   (res_sad)
    );

    int checks = 0;
    int fails  = 0;

    int cur_a [NN];
    int ref_a [NN][NE];
    int exp_a [NE];
    int exp_chk [NE];
    int trail [NN];
    int win [N+V-1][N+H-1];
    bit chk_due = 0;
    bit after_due = 0;
    string chk_tag = "R2";

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // Element index visited by the sum that ends in element e, per pixel index.
    function automatic void make_trail(input int e);
        int r = e / H;
        int c = e % H;
        for (int t = NN - 1; t >= 0; t--) begin
            trail[t] = r * H + c;
            if (t % N != 0) c = (c + 1) % H;
            else            r = (r + 1) % V;
        end
    endfunction

    // mode: 0 random, 1 window, 2 cur max/ref zero, 3 cur zero/ref max, 4 equal
    function automatic void gen(input int mode);
        for (int t = 0; t < NN; t++) begin
            cur_a[t] = (mode == 2) ? PMAX : (mode == 3) ? 0 : int'($urandom_range(PMAX, 0));
            for (int e = 0; e < NE; e++) begin
                case (mode)
                    2:       ref_a[t][e] = 0;
                    3:       ref_a[t][e] = PMAX;
                    4:       ref_a[t][e] = cur_a[t];
                    default: ref_a[t][e] = int'($urandom_range(PMAX, 0));
                endcase
            end
        end
        if (mode == 1) begin
            for (int y = 0; y < N + V - 1; y++)
                for (int x = 0; x < N + H - 1; x++)
                    win[y][x] = int'($urandom_range(PMAX, 0));
            for (int e = 0; e < NE; e++) begin
                make_trail(e);
                for (int t = 0; t < NN; t++)
                    ref_a[t][trail[t]] = win[e / H + t / N][e % H + t % N];
            end
            for (int e = 0; e < NE; e++) begin
                exp_a[e] = 0;
                for (int i = 0; i < N; i++)
                    for (int j = 0; j < N; j++)
                        exp_a[e] += absd(cur_a[i*N+j], win[e / H + i][e % H + j]);
            end
        end else begin
            for (int e = 0; e < NE; e++) begin
                make_trail(e);
                exp_a[e] = 0;
                for (int t = 0; t < NN; t++)
                    exp_a[e] += absd(cur_a[t], ref_a[t][trail[t]]);
            end
        end
    endfunction

    task automatic step(input bit v, input int t);
        @(negedge clk);
        if (chk_due) begin
            check("R4", "res_valid at strobe", int'(res_valid), 1);
            for (int e = 0; e < NE; e++)
                check(chk_tag, $sformatf("sad[%0d]", e), int'(res_sad[e*AW +: AW]), exp_chk[e]);
            chk_due   = 0;
            after_due = 1;
        end else if (after_due) begin
            check("R4", "res_valid one cycle later", int'(res_valid), 0);
            after_due = 0;
        end
        cur_valid = v;
        if (v) begin
            cur_pix = PW'(cur_a[t]);
            for (int e = 0; e < NE; e++) ref_pix[e*PW +: PW] = PW'(ref_a[t][e]);
        end else begin
            cur_pix = PW'($urandom);
            for (int e = 0; e < NE; e++) ref_pix[e*PW +: PW] = PW'($urandom);
        end
    endtask

    task automatic run_batch(input string tag, input int mode, input int gap_pct);
        gen(mode);
        for (int t = 0; t < NN; t++) begin
            while (int'($urandom_range(99, 0)) < gap_pct) step(0, 0);
            step(1, t);
        end
        exp_chk = exp_a;
        chk_tag = tag;
        chk_due = 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cur_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "res_valid after reset", int'(res_valid), 0);
        for (int e = 0; e < NE; e++)
            check("R1", $sformatf("sad[%0d] after reset", e), int'(res_sad[e*AW +: AW]), 0);
        chk_due = 0;
        after_due = 0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        do_reset();                       // R1 reset state

        run_batch("R2", 0, 0);            // R2 random path sums
        idle(2);
        run_batch("R2", 4, 0);            // R2 equal pixels, zero SAD
        idle(2);
        run_batch("R3", 1, 0);            // R3 window-fed direct SAD
        idle(2);
        run_batch("R3", 1, 0);
        idle(2);
        run_batch("R8", 2, 0);            // R8 maximum difference
        idle(2);
        run_batch("R8", 3, 0);
        idle(2);
        run_batch("R5", 0, 40);           // R5 stalls inside batch
        idle(2);
        run_batch("R6", 0, 0);            // R6 back to back
        run_batch("R6", 1, 0);
        run_batch("R6", 0, 0);
        idle(2);

        // R7: latches hold across idle garbage
        idle(12);
        check("R7", "res_valid during hold", int'(res_valid), 0);
        for (int e = 0; e < NE; e++)
            check("R7", $sformatf("sad[%0d] held", e), int'(res_sad[e*AW +: AW]), exp_chk[e]);

        // R9: reset partway through a batch
        gen(0);
        for (int t = 0; t < 7; t++) step(1, t);
        do_reset();
        run_batch("R9", 0, 0);
        idle(2);
        run_batch("R9", 0, 20);
        idle(3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule